// File: doc/BRIEF.md
# Relative-Addressed Floating Register Stack

This block is an eight-entry operand store for a floating-point datapath, organised as a circular stack. A three-bit top pointer picks the physical register that is currently the top, and every operand is named by its distance from that top: st(0) is the top, st(1) the entry below it, and so on up to st(7). The physical register for st(i) is (top + i) mod 8. A push moves the pointer down by one before it writes. A pop reads the top and then moves the pointer up by one. The data word is opaque to the block, because the arithmetic sits outside it.

Each cycle carries one command on `op_i`: NOP, PUSH, POP, XCHG or EXEC. Two read ports always show the operands of a two-input operation. Port A is always st(0). Port B is st(1) when `explicit_i` is low, and st(`idx_i`) when it is high. The outside arithmetic turns these into a result on `wb_data_i`. The EXEC command writes that result back to st(0) or to the second operand, and can pop the stack in the same cycle. The stack therefore works as an accumulator machine. XCHG swaps st(0) with st(`idx_i`) in one cycle.

Every physical entry has a tag that marks it empty or valid. A PUSH onto a valid entry is refused and reported as overflow. A command that uses an empty entry is refused and reported as underflow. In both cases the stack is left unchanged.

Top module: `rel_fp_stack`

## Requirements
- R1: After reset, `top_o` is 0, every bit of `rel_tags_o` is 0, and `ovf_o` and `unf_o` are low.
- R2: Bit i of `rel_tags_o` and the operand name st(i) refer to physical entry (`top_o` + i) mod 8. The top pointer wraps modulo 8.
- R3: PUSH (`op_i`=1) onto an empty st(7) has three effects: it writes `push_data_i` to that entry, it marks the entry valid, and it decrements `top_o`, so the pushed value becomes st(0).
- R4: PUSH when st(7) is valid raises `ovf_o` in the following cycle. It changes neither `top_o`, the tags nor the data.
- R5: During a POP (`op_i`=2), `opa_o` shows st(0). If st(0) is valid, the edge marks it empty and increments `top_o`.
- R6: Underflow is flagged and the stack is left unchanged in three cases: a POP with st(0) empty, an XCHG with st(0) or st(`idx_i`) empty, and an EXEC with st(0) or its second operand empty. In each case `unf_o` is high in the following cycle, and `top_o`, the tags and the data stay as they were.
- R7: `opa_o` always shows st(0). `opb_o` shows st(1) when `explicit_i`=0, and st(`idx_i`) when `explicit_i`=1.
- R8: XCHG (`op_i`=3) swaps the contents of st(0) and st(`idx_i`) in one cycle and leaves all tags unchanged.
- R9: EXEC (`op_i`=4) writes `wb_data_i` to st(0) when `dest_i`=0. When `dest_i`=1 it writes to the second operand, which is st(1) or st(`idx_i`) as selected by `explicit_i`.
- R10: EXEC with `pop_i`=1 performs its write and a pop on the same edge.
- R11: `ovf_o` and `unf_o` are one-cycle pulses. They are never high together, and both are low after any command that does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Command: 0 NOP, 1 PUSH, 2 POP, 3 XCHG, 4 EXEC |
| idx_i | input | 3 | Relative index i for st(i) |
| explicit_i | input | 1 | Second operand is st(idx_i) instead of st(1) |
| dest_i | input | 1 | EXEC result goes to the second operand instead of st(0) |
| pop_i | input | 1 | EXEC also pops after writing |
| push_data_i | input | W | Value loaded by PUSH |
| wb_data_i | input | W | Result written by EXEC |
| opa_o | output | W | st(0) |
| opb_o | output | W | Second operand |
| top_o | output | 3 | Physical index of st(0) |
| rel_tags_o | output | 8 | Valid tag of st(i), bit i |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |

## Verification
If the top pointer goes wrong, the error shows on the very next cycle. `top_o` moves, and `opa_o` and `rel_tags_o` rotate to the wrong neighbours. A lost or stray tag update shows on `rel_tags_o` one edge after the command that caused it. It also changes whether the next POP or PUSH faults. A bad write or swap index leaves the wrong value on `opa_o` or `opb_o` as soon as the bench names that slot. The directed tests therefore read back both operand ports after every command that changes the stack.

// File: rtl/fstk_pkg.sv
package fstk_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_XCHG = 3'd3,
        OP_EXEC = 3'd4
    } stk_op_e;

    typedef enum logic [1:0] {
        SRC_PUSH = 2'd0,
        SRC_XCH  = 2'd1,
        SRC_RES  = 2'd2
    } wsrc_e;
endpackage

// File: rtl/fstk_ctrl.sv
module fstk_ctrl
    import fstk_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  stk_op_e         op_i,
    input  logic [PW-1:0]   idx_i,
    input  logic            explicit_i,
    input  logic            dest_i,
    input  logic            pop_i,
    input  logic [DEPTH-1:0] tags_i,
    output logic [PW-1:0]   top_o,
    output logic [PW-1:0]   sec_o,
    output logic [PW-1:0]   xch_o,
    output logic            wa_en_o,
    output logic [PW-1:0]   wa_idx_o,
    output wsrc_e           wa_src_o,
    output logic            wb_en_o,
    output logic [PW-1:0]   wb_idx_o,
    output logic            set_en_o,
    output logic [PW-1:0]   set_idx_o,
    output logic            clr_en_o,
    output logic [PW-1:0]   clr_idx_o,
    output logic            ovf_o,
    output logic            unf_o
);
    logic [PW-1:0] top_q, top_d, push_idx, sec_rel;
    logic          ovf_d, unf_d;

    assign sec_rel  = explicit_i ? idx_i : PW'(1);
    assign sec_o    = top_q + sec_rel;
    assign xch_o    = top_q + idx_i;
    assign push_idx = top_q - PW'(1);
    assign top_o    = top_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            top_q <= top_d;
            ovf_o <= ovf_d;
            unf_o <= unf_d;
        end
    end

    always_comb begin
        top_d     = top_q;
        wa_en_o   = 1'b0;
        wa_idx_o  = top_q;
        wa_src_o  = SRC_PUSH;
        wb_en_o   = 1'b0;
        wb_idx_o  = top_q;
        set_en_o  = 1'b0;
        set_idx_o = push_idx;
        clr_en_o  = 1'b0;
        clr_idx_o = top_q;
        ovf_d     = 1'b0;
        unf_d     = 1'b0;
        unique case (op_i)
            OP_PUSH: begin
                if (tags_i[push_idx]) begin
                    ovf_d = 1'b1;
                end else begin
                    wa_en_o  = 1'b1;
                    wa_idx_o = push_idx;
                    wa_src_o = SRC_PUSH;
                    set_en_o = 1'b1;
                    top_d    = push_idx;
                end
            end
            OP_POP: begin
                if (!tags_i[top_q]) begin
                    unf_d = 1'b1;
                end else begin
                    clr_en_o = 1'b1;
                    top_d    = top_q + PW'(1);
                end
            end
            OP_XCHG: begin
                if (!tags_i[top_q] || !tags_i[xch_o]) begin
                    unf_d = 1'b1;
                end else begin
                    wa_en_o  = 1'b1;
                    wa_idx_o = top_q;
                    wa_src_o = SRC_XCH;
                    wb_en_o  = 1'b1;
                    wb_idx_o = xch_o;
                end
            end
            OP_EXEC: begin
                if (!tags_i[top_q] || !tags_i[sec_o]) begin
                    unf_d = 1'b1;
                end else begin
                    wa_en_o  = 1'b1;
                    wa_idx_o = dest_i ? sec_o : top_q;
                    wa_src_o = SRC_RES;
                    if (pop_i) begin
                        clr_en_o = 1'b1;
                        top_d    = top_q + PW'(1);
                    end
                end
            end
            default: begin
            end
        endcase
    end

    // R4
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> top_q == $past(top_q));

    // R6
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> top_q == $past(top_q));

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));
endmodule

// File: rtl/fstk_tags.sv
module fstk_tags #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en_i,
    input  logic [PW-1:0]    set_idx_i,
    input  logic             clr_en_i,
    input  logic [PW-1:0]    clr_idx_i,
    output logic [DEPTH-1:0] tags_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags_o <= '0;
        end else begin
            if (clr_en_i) tags_o[clr_idx_i] <= 1'b0;
            if (set_en_i) tags_o[set_idx_i] <= 1'b1;
        end
    end

    // R4
    set_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |-> !tags_o[set_idx_i]);

    // R6
    clr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |-> tags_o[clr_idx_i]);
endmodule

// File: rtl/fstk_regs.sv
module fstk_regs #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      wa_en_i,
    input  logic [PW-1:0]             wa_idx_i,
    input  logic [W-1:0]              wa_data_i,
    input  logic                      wb_en_i,
    input  logic [PW-1:0]             wb_idx_i,
    input  logic [W-1:0]              wb_data_i,
    output logic [DEPTH-1:0][W-1:0]   q_o
);
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (wb_en_i && wb_idx_i == PW'(e))
                ent_q <= wb_data_i;
            else if (wa_en_i && wa_idx_i == PW'(e))
                ent_q <= wa_data_i;
        end
        assign q_o[e] = ent_q;
    end
endmodule

// File: rtl/rel_fp_stack.sv
module rel_fp_stack
    import fstk_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [PW-1:0]    idx_i,
    input  logic             explicit_i,
    input  logic             dest_i,
    input  logic             pop_i,
    input  logic [W-1:0]     push_data_i,
    input  logic [W-1:0]     wb_data_i,
    output logic [W-1:0]     opa_o,
    output logic [W-1:0]     opb_o,
    output logic [PW-1:0]    top_o,
    output logic [DEPTH-1:0] rel_tags_o,
    output logic             ovf_o,
    output logic             unf_o
);
    logic [PW-1:0]           top, sec, xch, wa_idx, wb_idx, set_idx, clr_idx;
    logic                    wa_en, wb_en, set_en, clr_en;
    wsrc_e                   wa_src;
    logic [DEPTH-1:0]        tags;
    logic [DEPTH-1:0][W-1:0] q;
    logic [W-1:0]            wa_data;

    fstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op_i(stk_op_e'(op_i)), .idx_i(idx_i),
        .explicit_i(explicit_i), .dest_i(dest_i), .pop_i(pop_i), .tags_i(tags),
        .top_o(top), .sec_o(sec), .xch_o(xch),
        .wa_en_o(wa_en), .wa_idx_o(wa_idx), .wa_src_o(wa_src),
        .wb_en_o(wb_en), .wb_idx_o(wb_idx),
        .set_en_o(set_en), .set_idx_o(set_idx),
        .clr_en_o(clr_en), .clr_idx_o(clr_idx),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    fstk_tags #(.DEPTH(DEPTH)) u_tags (
        .clk(clk), .rst_n(rst_n), .set_en_i(set_en), .set_idx_i(set_idx),
        .clr_en_i(clr_en), .clr_idx_i(clr_idx), .tags_o(tags)
    );

    always_comb begin
        unique case (wa_src)
            SRC_XCH: wa_data = q[xch];
            SRC_RES: wa_data = wb_data_i;
            default: wa_data = push_data_i;
        endcase
    end

    fstk_regs #(.W(W), .DEPTH(DEPTH)) u_regs (
        .clk(clk), .wa_en_i(wa_en), .wa_idx_i(wa_idx), .wa_data_i(wa_data),
        .wb_en_i(wb_en), .wb_idx_i(wb_idx), .wb_data_i(q[top]), .q_o(q)
    );

    assign opa_o = q[top];
    assign opb_o = q[sec];
    assign top_o = top;

    for (genvar r = 0; r < DEPTH; r++) begin : g_rel
        assign rel_tags_o[r] = tags[top + PW'(r)];
    end

    // R3
    push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_i) == 3'd1 && !ovf_o
            |-> $countones(tags) == $countones($past(tags)) + 1);

    // R5
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_i) == 3'd2 && !unf_o
            |-> $countones(tags) + 1 == $countones($past(tags)));

    // R8
    xchg_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_i) == 3'd3 |-> $stable(tags));
endmodule

// File: tb/rel_fp_stack_tb.sv
module rel_fp_stack_tb;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_i = 3'd0;
    logic [2:0]    idx_i = 3'd0;
    logic          explicit_i = 1'b0;
    logic          dest_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [W-1:0]  push_data_i = '0;
    logic [W-1:0]  wb_data_i = '0;
    logic [W-1:0]  opa_o, opb_o;
    logic [2:0]    top_o;
    logic [7:0]    rel_tags_o;
    logic          ovf_o, unf_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rel_fp_stack #(.W(W), .DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i),
        .explicit_i(explicit_i), .dest_i(dest_i), .pop_i(pop_i),
        .push_data_i(push_data_i), .wb_data_i(wb_data_i),
        .opa_o(opa_o), .opb_o(opb_o), .top_o(top_o), .rel_tags_o(rel_tags_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [2:0] idx, input logic ex,
                         input logic dst, input logic pp, input logic [W-1:0] pd,
                         input logic [W-1:0] wd);
        op_i = op; idx_i = idx; explicit_i = ex; dest_i = dst; pop_i = pp;
        push_data_i = pd; wb_data_i = wd;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        op_i = 3'd0; idx_i = 3'd0; explicit_i = 1'b0; dest_i = 1'b0; pop_i = 1'b0;
        #0.5;
    endtask

    task automatic push(input logic [W-1:0] v);
        drive(3'd1, 3'd0, 1'b0, 1'b0, 1'b0, v, '0);
        tick();
    endtask

    task automatic t_reset();
        chk("R1 top", W'(top_o), 0);
        chk("R1 tags", W'(rel_tags_o), 0);
        chk("R1 flags", W'({ovf_o, unf_o}), 0);
    endtask

    task automatic t_push_select();
        push(32'h10); push(32'h20); push(32'h30);
        chk("R3 top after three pushes", W'(top_o), 5);
        chk("R2 rel tags", W'(rel_tags_o), 32'h07);
        chk("R3 st0 is last push", opa_o, 32'h30);
        chk("R7 implicit st1", opb_o, 32'h20);
        drive(3'd0, 3'd2, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R7 explicit st2", opb_o, 32'h10);
        tick();
        chk("R11 flags quiet", W'({ovf_o, unf_o}), 0);
    endtask

    task automatic t_xchg();
        drive(3'd3, 3'd2, 1'b0, 1'b0, 1'b0, '0, '0);
        tick();
        chk("R8 st0 after swap", opa_o, 32'h10);
        drive(3'd0, 3'd2, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R8 st2 after swap", opb_o, 32'h30);
        chk("R8 tags kept", W'(rel_tags_o), 32'h07);
        chk("R8 no fault", W'({ovf_o, unf_o}), 0);
        tick();
    endtask

    task automatic t_exec();
        drive(3'd4, 3'd0, 1'b0, 1'b0, 1'b0, '0, 32'h111);
        tick();
        chk("R9 dest st0", opa_o, 32'h111);
        drive(3'd4, 3'd2, 1'b1, 1'b1, 1'b0, '0, 32'h222);
        tick();
        drive(3'd0, 3'd2, 1'b1, 1'b0, 1'b0, '0, '0);
        chk("R9 dest st2", opb_o, 32'h222);
        chk("R9 st0 untouched", opa_o, 32'h111);
        tick();
        drive(3'd4, 3'd0, 1'b0, 1'b1, 1'b1, '0, 32'h333);
        tick();
        chk("R10 top after write+pop", W'(top_o), 6);
        chk("R10 st0 is written st1", opa_o, 32'h333);
        chk("R10 st1", opb_o, 32'h222);
        chk("R10 tags", W'(rel_tags_o), 32'h03);
    endtask

    task automatic t_underflow();
        drive(3'd2, 3'd0, 1'b0, 1'b0, 1'b0, '0, '0);
        chk("R5 pop shows st0", opa_o, 32'h333);
        tick();
        chk("R5 top after pop", W'(top_o), 7);
        chk("R5 tags after pop", W'(rel_tags_o), 32'h01);
        drive(3'd2, 3'd0, 1'b0, 1'b0, 1'b0, '0, '0);
        tick();
        chk("R2 top wraps to 0", W'(top_o), 0);
        chk("R5 empty stack", W'(rel_tags_o), 0);
        drive(3'd2, 3'd0, 1'b0, 1'b0, 1'b0, '0, '0);
        tick();
        chk("R6 pop empty unf", W'(unf_o), 1);
        chk("R6 top kept", W'(top_o), 0);
        chk("R11 no ovf with unf", W'(ovf_o), 0);
        tick();
        chk("R11 unf one pulse", W'(unf_o), 0);
        drive(3'd3, 3'd1, 1'b0, 1'b0, 1'b0, '0, '0);
        tick();
        chk("R6 xchg empty unf", W'(unf_o), 1);
        push(32'h5);
        drive(3'd4, 3'd0, 1'b0, 1'b0, 1'b0, '0, 32'h77);
        tick();
        chk("R6 exec with empty st1 unf", W'(unf_o), 1);
        chk("R6 st0 not written", opa_o, 32'h5);
        chk("R6 tags kept", W'(rel_tags_o), 32'h01);
        chk("R6 top kept after exec", W'(top_o), 7);
    endtask

    task automatic t_overflow();
        for (int k = 1; k <= 7; k++) push(32'h100 + W'(k));
        chk("R3 full stack", W'(rel_tags_o), 32'hFF);
        chk("R2 top wrapped", W'(top_o), 0);
        drive(3'd1, 3'd0, 1'b0, 1'b0, 1'b0, 32'h999, '0);
        tick();
        chk("R4 ovf raised", W'(ovf_o), 1);
        chk("R4 top kept", W'(top_o), 0);
        chk("R4 st0 kept", opa_o, 32'h107);
        chk("R4 tags kept", W'(rel_tags_o), 32'hFF);
        tick();
        chk("R11 ovf one pulse", W'(ovf_o), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #0.5;
        t_reset();
        t_push_select();
        t_xchg();
        t_exec();
        t_underflow();
        t_overflow();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule